// File: doc/BRIEF.md
# Shader Program Sequencer with Return Stack

This block stores a shader program in a 1024-word on-chip memory and walks through it one instruction per clock. The memory is filled through a small write port: one register selection clears the load pointer, and eight aliased selections each store a word at the pointer and move the pointer on by one. This lets a host stream a program in with no address traffic.

A start pulse launches a run from a configurable entry offset. Each fetched word is presented with a valid strobe to the execution units downstream. A subroutine call saves its own address on an eight-entry return stack and jumps to the target held in the word. A return resumes at the word after the matching call. A return that finds the stack empty ends the run and raises a one-cycle done pulse.

The block also keeps two condition flags. The execution units may write them, and every run starts with both flags clear.

Top module: `shader_sequencer`

## Requirements
- R1: After reset, instr_valid, run_done, call_overflow and both flags are 0 and the block is idle.
- R2: A write with cfg_sel = 0 clears the load pointer. A write with cfg_sel in 8..15 stores cfg_wdata at the pointer and then increments it, wrapping modulo 1024. A write with cfg_sel in 1..7 changes neither memory nor pointer.
- R3: A start pulse while idle begins a run at word entry_ofs modulo 1024. The first word appears on instr_word with instr_valid one cycle after the start is taken. From then on one word is presented every cycle, with no gaps, until the run ends.
- R4: A word whose opcode (bits 31:26) is neither 0x24 nor 0x21 moves execution to the next word, wrapping from 1023 to 0. This includes the flush opcode 0x22.
- R5: A word with opcode 0x24 (call) pushes its own address when fewer than 8 entries are in use, and execution continues at bits 21:10 of the word modulo 1024.
- R6: A word with opcode 0x21 (return), when the stack holds an entry, pops the newest saved address and continues at that address plus one. The popped slot is marked invalid.
- R7: A return with an empty stack ends the run. run_done is 1 for exactly the cycle in which that return word is presented with instr_valid, and the block is idle in the following cycle.
- R8: A call made while all 8 stack entries are in use pushes nothing and continues at the next word. It sets call_overflow, which holds until the next accepted start or reset.
- R9: A start pulse during a run, including in the cycle the ending return is fetched, has no effect.
- R10: flag_we[i] loads flag_wdata[i] into flags[i] at any time. An accepted start clears both flags and wins over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Program load write strobe |
| cfg_sel | input | 4 | Load register select: 0 pointer clear, 8..15 data alias |
| cfg_wdata | input | 32 | Program word to store |
| start | input | 1 | Begin a run when idle |
| entry_ofs | input | 16 | Entry word offset |
| flag_we | input | 2 | Per-flag write enable from execution units |
| flag_wdata | input | 2 | Flag write values |
| instr_word | output | 32 | Fetched instruction word |
| instr_valid | output | 1 | instr_word holds a newly fetched word |
| run_done | output | 1 | One-cycle pulse with the terminating return |
| call_overflow | output | 1 | Sticky: a call found the stack full |
| flags | output | 2 | Condition flags |

## Verification
A start pulse can land in the same cycle as the fetch of the ending return word. The bench computes the exact cycle of the ending return from its own program model and raises start with a different entry offset in that cycle. It then requires that no new word appears in the following cycle. A start and a flag write can also fall in the same cycle. This is provoked by driving both together, and the result is judged by expecting both flags to be clear afterwards.

// File: rtl/shader_seq_pkg.sv
package shader_seq_pkg;
    localparam int WORD_W  = 32;
    localparam int OPC_LSB = 26;
    localparam int OPC_W   = 6;
    localparam int TGT_LSB = 10;
    localparam int SEL_W   = 4;
    localparam int FLAG_N  = 2;

    localparam logic [OPC_W-1:0] OPC_RET   = 6'h21;
    localparam logic [OPC_W-1:0] OPC_FLUSH = 6'h22;
    localparam logic [OPC_W-1:0] OPC_CALL  = 6'h24;

    localparam logic [SEL_W-1:0] SEL_PTR_CLR = 4'h0;

    // Selections 8..15 all alias the same data port
    function automatic logic is_data_sel(input logic [SEL_W-1:0] s);
        return s[SEL_W-1];
    endfunction
endpackage

// File: rtl/seq_prog_mem.sv
module seq_prog_mem
    import shader_seq_pkg::*;
#(
    parameter int MEM_WORDS = 1024,
    localparam int AW = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    typedef struct packed {
        logic [AW-1:0] ptr;
    } ld_st_t;

    ld_st_t st_d, st_q;
    logic mem_we;
    logic [WORD_W-1:0] mem_q [MEM_WORDS];

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (wr_en) begin
            if (wr_sel == SEL_PTR_CLR) begin
                st_d.ptr = '0;
            end else if (is_data_sel(wr_sel)) begin
                mem_we   = 1'b1;
                st_d.ptr = st_q.ptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem_q[st_q.ptr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];

    p_ptr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_PTR_CLR) |=> (st_q.ptr == '0));
    p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel[SEL_W-1]) |=> (st_q.ptr == $past(st_q.ptr) + AW'(1)));
    p_ptr_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || (wr_sel != SEL_PTR_CLR && !wr_sel[SEL_W-1])) |=> $stable(st_q.ptr));
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int DEPTH = 8,
    parameter int AW    = 10,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic          top_live,
    output logic [AW-1:0] top_addr,
    output logic          full
);
    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] ent;
        logic [DEPTH-1:0]         live;   // 0 = invalid marker
        logic [CW-1:0]            cnt;
    } stk_st_t;

    stk_st_t st_d, st_q;
    logic [CW-1:0] top_idx;

    assign top_idx = st_q.cnt - CW'(1);
    assign full    = (st_q.cnt == CW'(DEPTH));

    always_comb begin
        top_live = 1'b0;
        top_addr = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.cnt != '0 && CW'(i) == top_idx) begin
                top_live = st_q.live[i];
                top_addr = st_q.ent[i];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.live = '0;
            st_d.cnt  = '0;
        end else if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == st_q.cnt) begin
                    st_d.ent[i]  = push_addr;
                    st_d.live[i] = 1'b1;
                end
            end
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (pop && st_q.cnt != '0) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == top_idx) st_d.live[i] = 1'b0;
            end
            st_d.cnt = top_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_push_not_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_pop_has_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> top_live);
    p_depth_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !top_live);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import shader_seq_pkg::*;
#(
    parameter int AW      = 10,
    parameter int ENTRY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ENTRY_W-1:0] entry_ofs,
    input  logic [FLAG_N-1:0]  flag_we,
    input  logic [FLAG_N-1:0]  flag_wdata,
    output logic [AW-1:0]      fetch_addr,
    input  logic [WORD_W-1:0]  fetch_data,
    output logic               stk_clr,
    output logic               stk_push,
    output logic [AW-1:0]      stk_push_addr,
    output logic               stk_pop,
    input  logic               stk_top_live,
    input  logic [AW-1:0]      stk_top_addr,
    input  logic               stk_full,
    output logic [WORD_W-1:0]  instr_word,
    output logic               instr_valid,
    output logic               run_done,
    output logic               call_overflow,
    output logic [FLAG_N-1:0]  flags
);
    typedef struct packed {
        logic              run;
        logic [AW-1:0]     pc;
        logic [WORD_W-1:0] instr;
        logic              valid;
        logic              done;
        logic              ovf;
        logic [FLAG_N-1:0] flags;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [OPC_W-1:0] opc;
    logic [AW-1:0]    pc_inc;
    logic [AW-1:0]    call_tgt;
    logic             go;
    logic             unused_entry_hi;

    assign opc             = fetch_data[OPC_LSB +: OPC_W];
    assign pc_inc          = st_q.pc + AW'(1);
    assign call_tgt        = fetch_data[TGT_LSB +: AW];
    assign go              = start && !st_q.run;
    assign unused_entry_hi = ^entry_ofs[ENTRY_W-1:AW];

    always_comb begin
        st_d          = st_q;
        st_d.valid    = 1'b0;
        st_d.done     = 1'b0;
        stk_clr       = 1'b0;
        stk_push      = 1'b0;
        stk_pop       = 1'b0;
        stk_push_addr = st_q.pc;
        if (go) begin
            st_d.run   = 1'b1;
            st_d.pc    = entry_ofs[AW-1:0];
            st_d.ovf   = 1'b0;
            stk_clr    = 1'b1;
        end else if (st_q.run) begin
            st_d.instr = fetch_data;
            st_d.valid = 1'b1;
            case (opc)
                OPC_CALL: begin
                    if (stk_full) begin
                        st_d.ovf = 1'b1;
                        st_d.pc  = pc_inc;
                    end else begin
                        stk_push = 1'b1;
                        st_d.pc  = call_tgt;
                    end
                end
                OPC_RET: begin
                    if (!stk_top_live) begin
                        st_d.run  = 1'b0;
                        st_d.done = 1'b1;
                    end else begin
                        stk_pop  = 1'b1;
                        st_d.pc  = stk_top_addr + AW'(1);
                    end
                end
                default: st_d.pc = pc_inc;
            endcase
        end
        for (int i = 0; i < FLAG_N; i++) begin
            if (go)              st_d.flags[i] = 1'b0;
            else if (flag_we[i]) st_d.flags[i] = flag_wdata[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_addr    = st_q.pc;
    assign instr_word    = st_q.instr;
    assign instr_valid   = st_q.valid;
    assign run_done      = st_q.done;
    assign call_overflow = st_q.ovf;
    assign flags         = st_q.flags;

    p_done_with_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> instr_valid);
    p_done_goes_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> !st_q.run);
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (call_overflow && !go) |=> call_overflow);
    p_flags_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (flags == '0));
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_q.run && opc != OPC_CALL && opc != OPC_RET)
        |=> (st_q.pc == $past(st_q.pc) + AW'(1)));
endmodule

// File: rtl/shader_sequencer.sv
module shader_sequencer
    import shader_seq_pkg::*;
#(
    parameter int MEM_WORDS   = 1024,
    parameter int STACK_DEPTH = 8,
    parameter int ENTRY_W     = 16,
    localparam int AW         = $clog2(MEM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [WORD_W-1:0]  cfg_wdata,
    input  logic               start,
    input  logic [ENTRY_W-1:0] entry_ofs,
    input  logic [FLAG_N-1:0]  flag_we,
    input  logic [FLAG_N-1:0]  flag_wdata,
    output logic [WORD_W-1:0]  instr_word,
    output logic               instr_valid,
    output logic               run_done,
    output logic               call_overflow,
    output logic [FLAG_N-1:0]  flags
);
    logic [AW-1:0]     fetch_addr;
    logic [WORD_W-1:0] fetch_data;
    logic              stk_clr, stk_push, stk_pop, stk_top_live, stk_full;
    logic [AW-1:0]     stk_push_addr, stk_top_addr;

    seq_prog_mem #(.MEM_WORDS(MEM_WORDS)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .rd_addr (fetch_addr),
        .rd_data (fetch_data)
    );

    seq_ret_stack #(.DEPTH(STACK_DEPTH), .AW(AW)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (stk_clr),
        .push      (stk_push),
        .push_addr (stk_push_addr),
        .pop       (stk_pop),
        .top_live  (stk_top_live),
        .top_addr  (stk_top_addr),
        .full      (stk_full)
    );

    seq_ctrl #(.AW(AW), .ENTRY_W(ENTRY_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .entry_ofs     (entry_ofs),
        .flag_we       (flag_we),
        .flag_wdata    (flag_wdata),
        .fetch_addr    (fetch_addr),
        .fetch_data    (fetch_data),
        .stk_clr       (stk_clr),
        .stk_push      (stk_push),
        .stk_push_addr (stk_push_addr),
        .stk_pop       (stk_pop),
        .stk_top_live  (stk_top_live),
        .stk_top_addr  (stk_top_addr),
        .stk_full      (stk_full),
        .instr_word    (instr_word),
        .instr_valid   (instr_valid),
        .run_done      (run_done),
        .call_overflow (call_overflow),
        .flags         (flags)
    );
endmodule

// File: tb/tb_shader_sequencer.sv
module tb_shader_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int MEMN       = 1024;
    localparam int TMAX       = 4096;

    logic        clk, rst_n, cfg_we, start;
    logic [3:0]  cfg_sel;
    logic [31:0] cfg_wdata;
    logic [15:0] entry_ofs;
    logic [1:0]  flag_we, flag_wdata;
    logic [31:0] instr_word;
    logic        instr_valid, run_done, call_overflow;
    logic [1:0]  flags;

    shader_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .start(start), .entry_ofs(entry_ofs),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .instr_word(instr_word),
        .instr_valid(instr_valid), .run_done(run_done),
        .call_overflow(call_overflow), .flags(flags)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mm [MEMN];
    logic [31:0] trace [TMAX];
    int trace_len;
    bit trace_ovf;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] plain_word();
        logic [31:0] w;
        w = $urandom();
        w[31] = 1'b0;                      // opcodes 0x00..0x1F
        if (($urandom() % 8) == 0) w[31:26] = 6'h22;  // flush
        return w;
    endfunction

    function automatic logic [31:0] mk_call(input int tgt);
        logic [11:0] t;
        t = 12'(tgt & 1023) | (12'($urandom() % 4) << 10);
        return {6'h24, 4'($urandom()), t, 10'($urandom())};
    endfunction

    function automatic logic [31:0] mk_ret();
        return {6'h21, 26'($urandom())};
    endfunction

    // Reference model of a run, built from the requirements
    task automatic model(input int entry);
        int pc, sp;
        int stk [8];
        logic [31:0] w;
        bit fin;
        pc = entry & 1023; sp = 0; trace_len = 0; trace_ovf = 0; fin = 0;
        while (!fin && trace_len < TMAX) begin
            w = mm[pc];
            trace[trace_len] = w;
            trace_len++;
            if (w[31:26] == 6'h24) begin
                if (sp == 8) begin trace_ovf = 1; pc = (pc + 1) & 1023; end
                else begin stk[sp] = pc; sp++; pc = int'(w[21:10]) & 1023; end
            end else if (w[31:26] == 6'h21) begin
                if (sp == 0) fin = 1;
                else begin sp--; pc = (stk[sp] + 1) & 1023; end
            end else begin
                pc = (pc + 1) & 1023;
            end
        end
    endtask

    task automatic write_cfg(input logic [3:0] sel, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_all();
        write_cfg(4'h8, $urandom());       // stray write before pointer clear
        write_cfg(4'h0, $urandom());
        for (int a = 0; a < MEMN; a++) begin
            if (($urandom() % 16) == 0) write_cfg(4'(1 + $urandom() % 7), $urandom());
            write_cfg(4'(8 + $urandom() % 8), mm[a]);
        end
    endtask

    task automatic run_check(input int entry, input string req, input bit poke);
        model(entry);
        start = 1'b1; entry_ofs = 16'(entry);
        @(negedge clk);
        start = 1'b0;
        check(instr_valid == 1'b0, "R3 no word in start cycle", 32'(instr_valid), 32'd0);
        for (int i = 0; i < trace_len; i++) begin
            @(negedge clk);
            start = 1'b0;
            check(instr_valid == 1'b1, "R3 continuous valid", 32'(instr_valid), 32'd1);
            check(instr_word == trace[i], req, instr_word, trace[i]);
            check(run_done == (i == trace_len - 1), "R7 done timing", 32'(run_done), 32'(i == trace_len - 1));
            if (poke && i == trace_len - 2) begin
                start = 1'b1; entry_ofs = 16'($urandom());
            end
        end
        @(negedge clk);
        start = 1'b0;
        check(instr_valid == 1'b0 && run_done == 1'b0, "R9 idle after end, late start ignored",
              {30'd0, instr_valid, run_done}, 32'd0);
        check(call_overflow == trace_ovf, "R8 overflow flag", 32'(call_overflow), 32'(trace_ovf));
    endtask

    task automatic fill_plain();
        for (int a = 0; a < MEMN; a++) mm[a] = plain_word();
    endtask

    task automatic build_prog(input int e);
        int sb [3];
        int n, p;
        fill_plain();
        for (int k = 0; k < 3; k++) sb[k] = (e + 150 + k * 250) & 1023;
        for (int k = 0; k < 3; k++) begin
            n = 1 + $urandom() % 5;
            p = sb[k];
            for (int j = 0; j < n; j++) begin
                if (k < 2 && j == n - 1 && ($urandom() % 2) == 0) mm[p] = mk_call(sb[k+1]);
                p = (p + 1) & 1023;
            end
            mm[p] = mk_ret();
        end
        n = 2 + $urandom() % 14;
        p = e & 1023;
        for (int j = 0; j < n; j++) begin
            if (($urandom() % 10) < 3) mm[p] = mk_call(sb[$urandom() % 3]);
            p = (p + 1) & 1023;
        end
        mm[p] = mk_ret();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int e;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        start = 1'b0; entry_ofs = '0; flag_we = '0; flag_wdata = '0;
        repeat (3) @(negedge clk);
        check({instr_valid, run_done, call_overflow, flags} == 5'd0, "R1 reset state",
              {27'd0, instr_valid, run_done, call_overflow, flags}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(instr_valid == 1'b0, "R1 idle after reset", 32'(instr_valid), 32'd0);

        // R4: straight-line code across the wrap, entry upper bits ignored (R3)
        fill_plain();
        mm[1022] = {6'h22, 26'($urandom())};
        mm[0] = mk_ret();
        load_all();
        run_check(16'hA400 | 1020, "R4 wrap word", 0);

        // R5 / R6: nested calls and returns, start poked near end (R9)
        fill_plain();
        mm[40] = mk_call(300); mm[42] = mk_ret();
        mm[301] = mk_call(500); mm[302] = mk_ret();
        mm[500] = mk_ret();
        load_all();
        run_check(40, "R6 call/return word", 1);

        // R8: self-recursive call fills the stack
        fill_plain();
        mm[16] = mk_call(100); mm[17] = mk_ret();
        mm[100] = mk_call(100); mm[101] = mk_ret();
        load_all();
        run_check(16, "R8 overflow word", 0);
        check(call_overflow == 1'b1, "R8 sticky after run", 32'(call_overflow), 32'd1);

        // R2: partial reload through aliases, ignored selections in between
        write_cfg(4'h0, 32'd0);
        mm[0] = plain_word(); write_cfg(4'hB, mm[0]);
        write_cfg(4'h3, mk_ret());
        mm[1] = plain_word(); write_cfg(4'hF, mm[1]);
        write_cfg(4'h7, mk_ret());
        mm[2] = mk_ret();     write_cfg(4'h8, mm[2]);
        run_check(0, "R2 reloaded word", 0);
        check(call_overflow == 1'b0, "R8 cleared by start", 32'(call_overflow), 32'd0);

        // R10: flag write while idle, then start colliding with a write
        flag_we = 2'b11; flag_wdata = 2'b10;
        @(negedge clk);
        flag_we = 2'b00;
        check(flags == 2'b10, "R10 flag write", 32'(flags), 32'd2);
        start = 1'b1; entry_ofs = 16'd2; flag_we = 2'b11; flag_wdata = 2'b11;
        @(negedge clk);
        start = 1'b0; flag_we = 2'b00;
        check(flags == 2'b00, "R10 start wins over write", 32'(flags), 32'd0);
        @(negedge clk);
        check(instr_valid && run_done && instr_word == mm[2], "R7 lone return ends run",
              instr_word, mm[2]);
        @(negedge clk);

        // Random programs (R5)
        for (int t = 0; t < 20; t++) begin
            e = int'($urandom() % 1024);
            build_prog(e);
            load_all();
            run_check(e, "R5 random program word", bit'($urandom() % 2));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule